// File: doc/BRIEF.md
# Programmable BCD Frequency Divider

This block divides its input clock by a programmable ratio N and emits a one-clock-wide pulse once every N enabled clocks. N is not a binary number. A 3-bit mode select chooses a first-stage modulus M. A 16-bit preset word supplies a remainder R, a most-significant quotient digit, and three BCD decades. The ratio is N = M * Q + R, where Q = MSD * 1000 + the three-decade BCD value.

Internally a synchronous binary down counter runs from N-1 to zero. While the counter sits at zero, a terminal flag is raised. On the next enabled clock the counter reloads from the current preset. A preset change therefore takes effect only at the next reload. Ratios of 0 and 1 degenerate to a pulse on every enabled clock. A typical use is to derive a low-rate tick from a fast reference, for example 2341 or 2340 from mode 3'b011 with preset 16'h5851 or 16'h5850.

Top module: `bcd_divider`

## Requirements
- R1: `mode_i` selects the modulus M as follows: 3'b000 gives 2, 3'b001 gives 5, 3'b010 gives 8, 3'b011 gives 4, and every code 3'b1xx gives 10.
- R2: The remainder R occupies the lowest W bits of `jam_i`, with `jam_i[0]` as its LSB. W is 1, 3, 3, 2 and 4 for moduli 2, 5, 8, 4 and 10. The bits of `jam_i[3:0]` above the remainder form the MSD, so the MSD is empty for modulus 10. `jam_i[15:12]`, `jam_i[11:8]` and `jam_i[7:4]` are the hundreds, tens and units BCD digits.
- R3: With `en_i` held high, successive `pulse_o` pulses are exactly N = M*(MSD*1000 + BCD) + R clocks apart.
- R4: For N of 2 or more, `pulse_o` is high for exactly one clock per period.
- R5: When N is 0 or 1, `pulse_o` is high on every enabled clock.
- R6: While `en_i` is low, the count is frozen and `pulse_o` stays low. Counting resumes where it stopped.
- R7: A change of `mode_i` or `jam_i` does not disturb the period in progress. The new ratio applies from the next reload.
- R8: An asserted `rst_ni` puts the counter at terminal count at once. The first enabled clock after release produces a pulse.
- R9: `tc_o` is high whenever the counter is at terminal count, whatever the level of `en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable |
| mode_i | input | 3 | First-stage modulus select |
| jam_i | input | 16 | Preset word: remainder, MSD, three BCD decades |
| pulse_o | output | 1 | Divided output pulse |
| tc_o | output | 1 | Counter at terminal count |

## Verification
A vector table visits every mode code, including all four codes that alias to modulus 10. It uses presets that exercise each field on its own: the remainder alone, the BCD decades alone, and the MSD alone through a 12000 ratio. It also covers 2341 against 2340, which differ only in the remainder LSB. A wrong modulus, a misplaced field or an off-by-one reload each shifts the measured spacing by a distinct amount. Directed runs cover a mid-count enable drop, a preset change in mid-period, asynchronous reset in mid-count, and the ratios of 0 and 1.

// File: rtl/bcd_div_pkg.sv
`timescale 1ns/1ps
package bcd_div_pkg;

  typedef struct packed {
    logic [3:0] modulus;
    logic [2:0] rem_w;
  } stage_cfg_t;

  // R1 / R2: modulus and remainder width per mode code
  function automatic stage_cfg_t stage_cfg(input logic [2:0] sel);
    stage_cfg_t c;
    case (sel)
      3'b000:  c = '{modulus: 4'd2,  rem_w: 3'd1};
      3'b001:  c = '{modulus: 4'd5,  rem_w: 3'd3};
      3'b010:  c = '{modulus: 4'd8,  rem_w: 3'd3};
      3'b011:  c = '{modulus: 4'd4,  rem_w: 3'd2};
      default: c = '{modulus: 4'd10, rem_w: 3'd4};
    endcase
    return c;
  endfunction

  function automatic int unsigned pow10(input int n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

endpackage

// File: rtl/bcd_ratio_decode.sv
`timescale 1ns/1ps
module bcd_ratio_decode
  import bcd_div_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int CNT_W  = 16
) (
  input  logic [2:0]            mode_i,
  input  logic [4+4*DIGITS-1:0] jam_i,
  output logic [CNT_W-1:0]      ratio_o
);

  logic [31:0] dec_term [DIGITS];

  // weight each BCD decade
  for (genvar g = 0; g < DIGITS; g++) begin : g_decade
    assign dec_term[g] = 32'(jam_i[4+4*g +: 4]) * pow10(g);
  end

  stage_cfg_t  cfg;
  logic [3:0]  low, rem_mask, rem, msd;
  logic [31:0] quot, total;

  always_comb begin
    cfg      = stage_cfg(mode_i);
    low      = jam_i[3:0];
    rem_mask = 4'((5'd1 << cfg.rem_w) - 5'd1);
    rem      = low & rem_mask;
    msd      = low >> cfg.rem_w;
    quot     = 32'(msd) * pow10(DIGITS);
    for (int d = 0; d < DIGITS; d++) quot = quot + dec_term[d];
    total    = 32'(cfg.modulus) * quot + 32'(rem);
  end

  assign ratio_o = CNT_W'(total);

endmodule

// File: rtl/div_down_counter.sv
`timescale 1ns/1ps
module div_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             tc_o,
  output logic             pulse_o
);

  logic [CNT_W-1:0] cnt_q;

  assign tc_o    = (cnt_q == '0);
  assign pulse_o = tc_o & en_i;

  // reset parks at terminal count so the first enabled clock pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= tc_o ? load_i : cnt_q - CNT_W'(1);
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R6
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tc_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_RELOAD_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tc_o) |=> (cnt_q == $past(load_i))); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && load_i != '0) |=> !pulse_o); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tc_o && load_i == '0) |=> tc_o); // R5

endmodule

// File: rtl/bcd_divider.sv
`timescale 1ns/1ps
module bcd_divider #(
  parameter int DIGITS = 3,
  parameter int CNT_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [2:0]            mode_i,
  input  logic [4+4*DIGITS-1:0] jam_i,
  output logic                  pulse_o,
  output logic                  tc_o
);

  logic [CNT_W-1:0] ratio, load_val;

  bcd_ratio_decode #(.DIGITS(DIGITS), .CNT_W(CNT_W)) u_decode (
    .mode_i  (mode_i),
    .jam_i   (jam_i),
    .ratio_o (ratio)
  );

  // ratio 0 or 1 collapses to a zero reload: pulse every enabled clock
  assign load_val = (ratio <= CNT_W'(1)) ? '0 : ratio - CNT_W'(1);

  div_down_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (load_val),
    .tc_o    (tc_o),
    .pulse_o (pulse_o)
  );

  AST_PULSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> !pulse_o); // R6
  AST_TC_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !en_i) |=> tc_o); // R9

endmodule

// File: tb/bcd_divider_test.sv
`timescale 1ns/1ps
module bcd_divider_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] jam = 16'h0000;
  logic        pulse, tc;
  int          compared = 0;
  int          mismatched = 0;

  always #4 clk = ~clk; // 125 MHz

  bcd_divider uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .mode_i  (mode),
    .jam_i   (jam),
    .pulse_o (pulse),
    .tc_o    (tc)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] jam;
    logic [15:0] n;
  } vec_t;

  // R1 mode codes, R2 field layout, R3 expected ratio
  localparam vec_t VECS [13] = '{
    '{3'b011, 16'h5851, 16'd2341},
    '{3'b011, 16'h5850, 16'd2340},
    '{3'b000, 16'h0123, 16'd2025},
    '{3'b001, 16'h0124, 16'd64},
    '{3'b010, 16'h0107, 16'd87},
    '{3'b100, 16'h0259, 16'd259},
    '{3'b111, 16'h0003, 16'd3},
    '{3'b011, 16'h0001, 16'd1},
    '{3'b011, 16'h0000, 16'd0},
    '{3'b000, 16'h0011, 16'd3},
    '{3'b101, 16'h1000, 16'd1000},
    '{3'b110, 16'h0015, 16'd15},
    '{3'b011, 16'h000C, 16'd12000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; k = cycles until pulse seen (0 = current cycle)
  task automatic wait_pulse(input int lim, output int k);
    k = -1;
    for (int i = 0; i < lim; i++) begin
      #1;
      if (pulse) begin
        k = i;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int gap, found, idx;
    int p [3];
    gap = (v.n <= 1) ? 1 : int'(v.n);
    mode = v.mode; jam = v.jam; en = 1'b1; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    found = 0; idx = 0;
    while (found < 3 && idx < 3 * gap + 10) begin
      #1;
      if (pulse) begin
        p[found] = idx;
        found++;
      end
      @(negedge clk);
      idx++;
    end
    check(found == 3, "R3 pulses observed", found, 3);
    if (found == 3) begin
      check(p[0] == 0, "R8 first pulse after reset", p[0], 0);
      if (v.n <= 1) begin
        check(p[1] - p[0] == 1, "R5 pass-through spacing", p[1] - p[0], 1);
        check(p[2] - p[1] == 1, "R5 pass-through spacing", p[2] - p[1], 1);
      end else begin
        check(p[1] - p[0] == gap, "R3 R1 R2 R4 pulse spacing", p[1] - p[0], gap);
        check(p[2] - p[1] == gap, "R3 R1 R2 R4 pulse spacing", p[2] - p[1], gap);
      end
    end
  endtask

  task automatic run_all();
    int k;
    foreach (VECS[i]) run_vec(VECS[i]);

    // reset state and enable gating (R8, R9, R6)
    en = 1'b0; mode = 3'b111; jam = 16'h0005; rst_n = 1'b0;
    @(negedge clk); #1;
    check(tc == 1'b1, "R8 tc during reset", tc, 1);
    check(pulse == 1'b0, "R6 no pulse without enable", pulse, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check(tc == 1'b1, "R9 tc held with enable low", tc, 1);
    check(pulse == 1'b0, "R6 no pulse with enable low", pulse, 0);

    // freeze mid-count, N=5
    @(negedge clk); en = 1'b1;
    wait_pulse(10, k);
    check(k == 0, "R8 pulse on first enabled clock", k, 0);
    @(negedge clk); @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1;
      check(pulse == 1'b0 && tc == 1'b0, "R6 frozen count", {pulse, tc}, 0);
      @(negedge clk);
    end
    en = 1'b1;
    wait_pulse(20, k);
    check(k == 3, "R6 resume from frozen count", k, 3);

    // preset change mid-period, N=10 then N=4 (R7)
    @(negedge clk);
    jam = 16'h0010; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wait_pulse(5, k);
    @(negedge clk); @(negedge clk);
    jam = 16'h0004;
    wait_pulse(30, k);
    check(k == 8, "R7 period in progress keeps old ratio", k, 8);
    @(negedge clk);
    wait_pulse(30, k);
    check(k == 3, "R7 new ratio after reload", k, 3);

    // asynchronous reset mid-count (R8)
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0; #1;
    check(tc == 1'b1, "R8 async reset to terminal", tc, 1);
    @(negedge clk); rst_n = 1'b1;
    wait_pulse(5, k);
    check(k == 0, "R8 pulse right after reset", k, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule